// File: doc/BRIEF.md
# Supply and Manual Reset Pulse Generator

This block drives the processor reset pair from two request sources. One source is a supply-undervoltage flag, already synchronized to the clock. The other is an active-low manual reset pin that arrives asynchronously and may bounce. While either request is present, reset is held asserted. Once both have cleared, reset stays asserted for a fixed hold interval. If a fresh request arrives during that interval, the interval starts again from zero when all requests are gone.

The pin passes through a chain of synchronizer flops. It then passes through a persistence filter, which accepts a low level only after it has been seen for a set number of consecutive clock samples. Shorter low pulses are ignored. The block has two outputs, a primary reset and its exact complement. A parameter chooses whether the primary output is active-low (the default) or active-high.

All time constants are counted in clock ticks. At 50 MHz, the defaults give about a 200 ms hold. They also give a 500 ns minimum manual pulse, with assertion about 540 ns after the pin falls.

Top module: `rst_pulse_gen`

## Requirements
- R1: While `rst_n` is low, reset is asserted. After `rst_n` rises with no request present, reset deasserts on the HOLD_TICKS-th rising edge after the release. The manual input reads as inactive (high) from reset onward.
- R2: A high `supply_low` sampled on a rising edge asserts reset after that same edge.
- R3: When `supply_low` is first sampled low at edge e, with no other request present, reset stays asserted through edge e+HOLD_TICKS-2 and deasserts after edge e+HOLD_TICKS-1.
- R4: When `mr_n` is first sampled low at edge a and stays low, reset is still deasserted after edge a+SYNC_STAGES+FILT_TICKS-1 and is asserted after edge a+SYNC_STAGES+FILT_TICKS.
- R5: A low pulse on `mr_n` that is sampled low on fewer than FILT_TICKS consecutive edges has no effect. It neither asserts reset nor restarts a running hold interval.
- R6: When `mr_n` is first sampled high again at edge b after a recognized low, reset deasserts after edge b+SYNC_STAGES+HOLD_TICKS, provided no other request is present.
- R7: A request recognized during the hold interval restarts it. The full HOLD_TICKS count begins again after that request clears.
- R8: Reset stays asserted as long as either request is present, and the hold interval is timed from the release of the last one.
- R9: `rst_cmp` is always the bitwise complement of `rst_pri`.
- R10: With PRIMARY_ACTIVE_HIGH=0, `rst_pri` is 0 while reset is asserted. With PRIMARY_ACTIVE_HIGH=1, `rst_pri` is 1 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| supply_low | input | 1 | Synchronized undervoltage flag, high = supply below threshold |
| mr_n | input | 1 | Asynchronous manual reset pin, active low |
| rst_pri | output | 1 | Primary reset output, polarity set by PRIMARY_ACTIVE_HIGH |
| rst_cmp | output | 1 | Complement of `rst_pri` |

## Verification
The hardest case to reach is a restart that happens in the middle of a hold interval. To check it, the bench must show two things. First, reset stays asserted past the point where the original interval would have ended. Second, a manual glitch one sample too short does not move the release edge at all. The stimulus starts a supply-driven hold and then, a few cycles later, applies either a filtered-length or a just-too-short manual pulse. Expected release edges are computed from the pin's first sampled high level plus the synchronizer depth and the hold length. The bench samples the cycle just before each release edge as well as the release edge itself.

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int SYNC_STAGES         = 2,
  parameter int FILT_TICKS          = 25,
  parameter int HOLD_TICKS          = 10_000_000,
  parameter bit PRIMARY_ACTIVE_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic mr_n,
  output logic rst_pri,
  output logic rst_cmp
);
  localparam int HW = $clog2(HOLD_TICKS);
  localparam int FW = $clog2(FILT_TICKS + 1);

  logic [SYNC_STAGES-1:0] mr_sync;
  logic [FW-1:0]          flt_cnt;
  logic                   mr_req;
  logic [HW-1:0]          hold_cnt;
  logic                   asserting;
  logic                   mr_low;
  logic                   req_any;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mr_sync <= '1;
    else        mr_sync <= {mr_sync[SYNC_STAGES-2:0], mr_n};

  assign mr_low = ~mr_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_cnt <= '0;
      mr_req  <= 1'b0;
    end else if (!mr_low) begin
      flt_cnt <= '0;
      mr_req  <= 1'b0;
    end else if (!mr_req) begin
      if (flt_cnt == FW'(FILT_TICKS - 1)) mr_req <= 1'b1;
      else                                flt_cnt <= flt_cnt + 1'b1;
    end

  assign req_any = supply_low | mr_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold_cnt  <= '0;
      asserting <= 1'b1;
    end else if (req_any) begin
      hold_cnt  <= '0;
      asserting <= 1'b1;
    end else if (asserting) begin
      if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
        hold_cnt  <= '0;
        asserting <= 1'b0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end

  generate
    if (PRIMARY_ACTIVE_HIGH) begin : g_pri_high
      assign rst_pri = asserting;
    end else begin : g_pri_low
      assign rst_pri = ~asserting;
    end
  endgenerate

  assign rst_cmp = ~rst_pri;
endmodule

module rst_pulse_gen_chk #(
  parameter int HOLD_TICKS = 40,
  localparam int HW = $clog2(HOLD_TICKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_low,
  input logic          mr_req,
  input logic          asserting,
  input logic [HW-1:0] hold_cnt,
  input logic          rst_pri,
  input logic          rst_cmp
);
  AST_CMP_INVERSE: assert property (@(posedge clk) disable iff (!rst_n) rst_cmp == ~rst_pri); // R9
  AST_SUPPLY_FORCES: assert property (@(posedge clk) disable iff (!rst_n) supply_low |=> asserting); // R2
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $fell(asserting) |-> (!$past(supply_low) && !$past(mr_req))); // R8
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(asserting) |-> ($past(supply_low) || $past(mr_req))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) hold_cnt <= HW'(HOLD_TICKS - 1)); // R3
  AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (supply_low || mr_req) |=> (hold_cnt == '0)); // R7
endmodule

bind rst_pulse_gen rst_pulse_gen_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .mr_req(mr_req),
  .asserting(asserting), .hold_cnt(hold_cnt), .rst_pri(rst_pri), .rst_cmp(rst_cmp)
);

// File: tb/sim_rst_pulse_gen.sv
module sim_rst_pulse_gen;
  localparam int SY = 2;
  localparam int FT = 5;
  localparam int HT = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic p0, c0, p1, c1;

  rst_pulse_gen #(.SYNC_STAGES(SY), .FILT_TICKS(FT), .HOLD_TICKS(HT), .PRIMARY_ACTIVE_HIGH(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .mr_n(mr_n), .rst_pri(p0), .rst_cmp(c0));
  rst_pulse_gen #(.SYNC_STAGES(SY), .FILT_TICKS(FT), .HOLD_TICKS(HT), .PRIMARY_ACTIVE_HIGH(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .mr_n(mr_n), .rst_pri(p1), .rst_cmp(c1));

  typedef struct { int cyc; bit val; string tag; } exp_t;
  exp_t sbq[$];
  int edge_n = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic expect_at(int cyc, bit val, string tag);
    sbq.push_back('{cyc, val, tag});
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= edge_n) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (e.cyc != edge_n || c0 !== e.val) begin
        errors++;
        $display("FAIL %s cycle %0d: asserted(u0.rst_cmp)=%b expected %b", e.tag, e.cyc, c0, e.val);
      end
      checks++; // R9 complement on both instances
      if (p0 !== ~c0 || c1 !== ~p1) begin
        errors++;
        $display("FAIL R9 cycle %0d: pri0=%b cmp0=%b pri1=%b cmp1=%b expected complements", edge_n, p0, c0, p1, c1);
      end
      checks++; // R10 primary polarity of both variants
      if (p1 !== e.val || p0 !== ~e.val) begin
        errors++;
        $display("FAIL R10 cycle %0d: pri_high=%b pri_low=%b expected %b and %b", edge_n, p1, p0, e.val, ~e.val);
      end
    end
  end

  initial begin
    int c, c2, c3, c4, m, b;
    tick(3);
    expect_at(edge_n + 1, 1'b1, "R1 in reset");
    tick(2);
    c = edge_n; rst_n = 1'b1;
    expect_at(c + HT - 1, 1'b1, "R1 first hold");
    expect_at(c + HT, 1'b0, "R1 first release");
    tick(HT + 5);

    c = edge_n; supply_low = 1'b1;
    expect_at(c + 1, 1'b1, "R2 supply assert");
    tick(3);
    c = edge_n; supply_low = 1'b0;
    expect_at(c + HT - 1, 1'b1, "R3 hold end");
    expect_at(c + HT, 1'b0, "R3 release");
    tick(HT + 5);

    supply_low = 1'b1; tick(2);
    c2 = edge_n; supply_low = 1'b0;
    tick(20);
    c3 = edge_n; supply_low = 1'b1;
    expect_at(c3 + 1, 1'b1, "R7 reassert in hold");
    tick(1);
    c4 = edge_n; supply_low = 1'b0;
    expect_at(c2 + HT, 1'b1, "R7 old release skipped");
    expect_at(c4 + HT - 1, 1'b1, "R7 restarted hold");
    expect_at(c4 + HT, 1'b0, "R7 restarted release");
    tick(HT + 5);

    c = edge_n; mr_n = 1'b0;
    expect_at(c + SY + FT, 1'b0, "R4 before latency");
    expect_at(c + SY + FT + 1, 1'b1, "R4 at latency");
    tick(FT);
    mr_n = 1'b1; b = edge_n + 1;
    expect_at(b + SY + HT - 1, 1'b1, "R6 hold end");
    expect_at(b + SY + HT, 1'b0, "R6 release");
    tick(SY + HT + 5);

    c = edge_n; mr_n = 1'b0;
    tick(FT - 1);
    mr_n = 1'b1;
    expect_at(c + SY + FT + 1, 1'b0, "R5 glitch ignored");
    expect_at(c + SY + FT + 6, 1'b0, "R5 glitch ignored late");
    tick(20);

    supply_low = 1'b1; tick(2);
    c = edge_n; supply_low = 1'b0;
    tick(5);
    mr_n = 1'b0; tick(FT - 1); mr_n = 1'b1;
    expect_at(c + HT - 1, 1'b1, "R5 hold unchanged");
    expect_at(c + HT, 1'b0, "R5 release unchanged");
    tick(HT + 5);

    supply_low = 1'b1; tick(2);
    c = edge_n; supply_low = 1'b0;
    tick(5);
    m = edge_n; mr_n = 1'b0;
    tick(FT);
    mr_n = 1'b1; b = m + 1 + FT;
    expect_at(c + HT, 1'b1, "R7 manual restart");
    expect_at(b + SY + HT - 1, 1'b1, "R7 manual hold end");
    expect_at(b + SY + HT, 1'b0, "R7 manual release");
    tick(SY + HT + 5);

    supply_low = 1'b1; tick(1);
    mr_n = 1'b0; tick(3);
    c = edge_n; supply_low = 1'b0;
    expect_at(c + HT + 5, 1'b1, "R8 manual still held");
    tick(HT + 10);
    m = edge_n; mr_n = 1'b1; b = m + 1;
    expect_at(b + SY + HT - 1, 1'b1, "R8 hold end");
    expect_at(b + SY + HT, 1'b0, "R8 release");
    tick(SY + HT + 5);

    if (sbq.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R1 scoreboard: %0d items left, expected 0", sbq.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: run at cycle %0d, expected end", edge_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule